// File: doc/BRIEF.md
# Canvas Descriptor Table

This block keeps a table of 256 canvas descriptors. Each descriptor gives an image surface's base address, width, height, wrap flags, tiling mode and byte-swap control. Software never reaches an entry directly. It writes a descriptor into two staging words and then writes an index word whose strobe bits either commit the staged words into the chosen entry or load that entry back into the staging words for reading.

A separate translator port reads a descriptor by index and presents its fields, split out, one cycle later. The translator uses it to turn surface coordinates into memory addresses.

Top module: `canvas_desc_table`

## Requirements
- R1: After reset, all three registers read zero and every table entry is zero; a translator read of any entry then returns all-zero fields.
- R2: Byte offset 0x48 is the low staging word, 0x4C is the high staging word and 0x50 is the index word. A read of any other offset returns zero, and a write to another offset changes no register and no entry.
- R3: The high staging word reads bits 31:30 as zero. The index word reads back the last written index in bits 7:0 and reads zero in bits 31:8, so the strobes are not kept.
- R4: A bus write to the index word with bit 9 set writes the staged descriptor into the entry named by bits 7:0 of the write data, at that same clock edge.
- R5: Field layout. Low word: base address in bits 28:0, width bits 2:0 in bits 31:29. High word: width bits 11:3 in bits 8:0, height in 21:9, x-wrap in 22, y-wrap in 23, tiling mode in 25:24, swap control in 29:26. The 12-bit width is the high word's bits 8:0 placed above the low word's bits 31:29.
- R6: An index write with bit 8 set and bit 9 clear copies the named entry into both staging words. The copy is readable on the bus from the next cycle.
- R7: An index write with bits 8 and 9 both set performs the commit and skips the load, so the staging words keep their values.
- R8: A read that follows a commit observes the committed entry, whether the read comes through a load strobe or the translator port.
- R9: A translator read request presents the entry's fields on the translator outputs after the next clock edge. If a commit targets the same entry in the same cycle, the request returns the entry's previous contents.
- R10: While no translator request is made, the translator outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Register write enable |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr, combinational |
| xl_rd | input | 1 | Translator read request |
| xl_idx | input | 8 | Translator entry index |
| xl_base | output | 29 | Base address, in 8-byte units |
| xl_width | output | 12 | Width, in 8-byte units |
| xl_height | output | 13 | Height, in rows |
| xl_xwrap | output | 1 | Horizontal wrap enable |
| xl_ywrap | output | 1 | Vertical wrap enable |
| xl_tile | output | 2 | Tiling mode |
| xl_swap | output | 4 | Byte-swap control |

## Verification
A table of descriptors is committed to entries 0, 255 and several in between. The descriptors have alternating and one-hot bit patterns placed across the width split, so that a shifted or swapped field is caught. Each entry is then read back both through the load strobe and through the translator port. This separates errors in the commit path from errors in the field decode. Directed cases follow for the both-strobes write, a load right after a commit, a translator read that collides with a commit, the reserved bits and unmapped offsets.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int IDX_W    = 8;
  localparam int ADDR_W   = 8;
  localparam int BASE_W   = 29;
  localparam int WID_W    = 12;
  localparam int WID_LO_W = 3;
  localparam int WID_HI_W = WID_W - WID_LO_W;
  localparam int HGT_W    = 13;
  localparam int TILE_W   = 2;
  localparam int SWAP_W   = 4;
  localparam int HI_USED  = WID_HI_W + HGT_W + 2 + TILE_W + SWAP_W;

  typedef struct packed {
    logic [SWAP_W-1:0] swap;
    logic [TILE_W-1:0] tile;
    logic              ywrap;
    logic              xwrap;
    logic [HGT_W-1:0]  height;
    logic [WID_W-1:0]  width;
    logic [BASE_W-1:0] base;
  } cdt_desc_t;
endpackage

// File: rtl/cdt_rst_sync.sv
module cdt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/cdt_bus_regs.sv
module cdt_bus_regs
  import cdt_pkg::*;
#(
  parameter logic [ADDR_W-1:0] OFS_LO  = 8'h48,
  parameter logic [ADDR_W-1:0] OFS_HI  = 8'h4C,
  parameter logic [ADDR_W-1:0] OFS_IDX = 8'h50,
  parameter int RD_BIT = 8,
  parameter int WR_BIT = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output cdt_desc_t         stage_desc,
  output logic              commit,
  output logic              load,
  output logic [IDX_W-1:0]  sel_idx,
  input  cdt_desc_t         load_desc
);
  localparam int LO_BASE_W = BASE_W;

  logic [31:0]        lo_q, lo_d;
  logic [HI_USED-1:0] hi_q, hi_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic               lo_en, hi_en, idx_en;

  always_comb begin
    idx_en  = bus_we && (bus_addr == OFS_IDX);
    commit  = idx_en && bus_wdata[WR_BIT];
    load    = idx_en && bus_wdata[RD_BIT] && !bus_wdata[WR_BIT];
    sel_idx = bus_wdata[IDX_W-1:0];
    lo_en   = (bus_we && (bus_addr == OFS_LO)) || load;
    hi_en   = (bus_we && (bus_addr == OFS_HI)) || load;
  end

  always_comb begin
    lo_d  = lo_q;
    hi_d  = hi_q;
    idx_d = idx_q;
    if (load) begin
      lo_d = {load_desc.width[WID_LO_W-1:0], load_desc.base};
      hi_d = {load_desc.swap, load_desc.tile, load_desc.ywrap, load_desc.xwrap,
              load_desc.height, load_desc.width[WID_W-1:WID_LO_W]};
    end else begin
      if (bus_addr == OFS_LO) lo_d = bus_wdata;
      if (bus_addr == OFS_HI) hi_d = bus_wdata[HI_USED-1:0];
    end
    if (idx_en) idx_d = bus_wdata[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      idx_q <= '0;
    end else begin
      if (lo_en)  lo_q  <= lo_d;
      if (hi_en)  hi_q  <= hi_d;
      if (idx_en) idx_q <= idx_d;
    end
  end

  always_comb begin
    stage_desc.base   = lo_q[LO_BASE_W-1:0];
    stage_desc.width  = {hi_q[WID_HI_W-1:0], lo_q[31:32-WID_LO_W]};
    stage_desc.height = hi_q[WID_HI_W +: HGT_W];
    stage_desc.xwrap  = hi_q[WID_HI_W + HGT_W];
    stage_desc.ywrap  = hi_q[WID_HI_W + HGT_W + 1];
    stage_desc.tile   = hi_q[WID_HI_W + HGT_W + 2 +: TILE_W];
    stage_desc.swap   = hi_q[WID_HI_W + HGT_W + 2 + TILE_W +: SWAP_W];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFS_LO)       bus_rdata = lo_q;
    else if (bus_addr == OFS_HI)  bus_rdata[HI_USED-1:0] = hi_q;
    else if (bus_addr == OFS_IDX) bus_rdata[IDX_W-1:0] = idx_q;
  end

  p_hi_rsvd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_HI) |-> (bus_rdata[31:30] == 2'b00));
  p_idx_rsvd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_IDX) |-> (bus_rdata[31:IDX_W] == '0));
  p_both_strobes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && bus_wdata[RD_BIT]) |=> ($stable(lo_q) && $stable(hi_q)));
  p_load_visible_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (lo_q[BASE_W-1:0] == $past(load_desc.base)));
endmodule

// File: rtl/cdt_entry_store.sv
module cdt_entry_store
  import cdt_pkg::*;
#(
  parameter int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  cdt_desc_t        wr_data,
  input  logic [IDX_W-1:0] ra_idx,
  output cdt_desc_t        ra_data,
  input  logic [IDX_W-1:0] rb_idx,
  output cdt_desc_t        rb_data
);
  cdt_desc_t mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign ra_data = mem[ra_idx];
  assign rb_data = mem[rb_idx];

  p_commit_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mem[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/cdt_xl_port.sv
module cdt_xl_port
  import cdt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rd_en,
  input  cdt_desc_t rd_desc,
  output cdt_desc_t out_desc
);
  cdt_desc_t desc_q, desc_d;

  always_comb begin
    desc_d = desc_q;
    if (rd_en) desc_d = rd_desc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     desc_q <= '0;
    else if (rd_en) desc_q <= desc_d;
  end

  assign out_desc = desc_q;

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(desc_q));
  p_fresh_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (desc_q == $past(rd_desc)));
endmodule

// File: rtl/canvas_desc_table.sv
module canvas_desc_table
  import cdt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic               xl_rd,
  input  logic [IDX_W-1:0]   xl_idx,
  output logic [BASE_W-1:0]  xl_base,
  output logic [WID_W-1:0]   xl_width,
  output logic [HGT_W-1:0]   xl_height,
  output logic               xl_xwrap,
  output logic               xl_ywrap,
  output logic [TILE_W-1:0]  xl_tile,
  output logic [SWAP_W-1:0]  xl_swap
);
  logic             rst_n_sync;
  cdt_desc_t        stage_desc, load_desc, xl_raw, xl_desc;
  logic             commit, load;
  logic [IDX_W-1:0] sel_idx;

  cdt_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  cdt_bus_regs u_regs (
    .clk(clk), .rst_n(rst_n_sync),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .stage_desc(stage_desc), .commit(commit),
    .load(load), .sel_idx(sel_idx), .load_desc(load_desc)
  );

  cdt_entry_store u_store (
    .clk(clk), .rst_n(rst_n_sync),
    .wr_en(commit), .wr_idx(sel_idx), .wr_data(stage_desc),
    .ra_idx(sel_idx), .ra_data(load_desc),
    .rb_idx(xl_idx), .rb_data(xl_raw)
  );

  cdt_xl_port u_xl (
    .clk(clk), .rst_n(rst_n_sync),
    .rd_en(xl_rd), .rd_desc(xl_raw), .out_desc(xl_desc)
  );

  assign xl_base   = xl_desc.base;
  assign xl_width  = xl_desc.width;
  assign xl_height = xl_desc.height;
  assign xl_xwrap  = xl_desc.xwrap;
  assign xl_ywrap  = xl_desc.ywrap;
  assign xl_tile   = xl_desc.tile;
  assign xl_swap   = xl_desc.swap;
endmodule

// File: tb/canvas_desc_table_test.sv
module canvas_desc_table_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        xl_rd = 1'b0;
  logic [7:0]  xl_idx = '0;
  logic [28:0] xl_base;
  logic [11:0] xl_width;
  logic [12:0] xl_height;
  logic        xl_xwrap, xl_ywrap;
  logic [1:0]  xl_tile;
  logic [3:0]  xl_swap;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  canvas_desc_table uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .xl_rd(xl_rd),
    .xl_idx(xl_idx), .xl_base(xl_base), .xl_width(xl_width),
    .xl_height(xl_height), .xl_xwrap(xl_xwrap), .xl_ywrap(xl_ywrap),
    .xl_tile(xl_tile), .xl_swap(xl_swap)
  );

  localparam logic [7:0] A_LO = 8'h48, A_HI = 8'h4C, A_IX = 8'h50;

  typedef struct packed { logic [7:0] idx; logic [31:0] lo; logic [31:0] hi; } vec_t;
  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 32'hFFFF_FFFF, 32'h3FFF_FFFF},
    '{8'hFF, 32'hA555_5555, 32'h2AAA_AAAA},
    '{8'h01, 32'h5AAA_AAAA, 32'h1555_5555},
    '{8'h7E, 32'h2000_0001, 32'h0000_0001},
    '{8'h80, 32'h8000_0000, 32'h2040_0200},
    '{8'h33, 32'h1234_5678, 32'h0D87_6543}
  };

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic xl_read(input logic [7:0] i);
    xl_idx = i; xl_rd = 1'b1;
    @(negedge clk);
    xl_rd = 1'b0;
  endtask

  task automatic chk_xl(input string req, input logic [31:0] lo, input logic [31:0] hi);
    chk(req, "base",   xl_base,   lo[28:0]);
    chk(req, "width",  xl_width,  {hi[8:0], lo[31:29]});
    chk(req, "height", xl_height, hi[21:9]);
    chk(req, "xwrap",  xl_xwrap,  hi[22]);
    chk(req, "ywrap",  xl_ywrap,  hi[23]);
    chk(req, "tile",   xl_tile,   hi[25:24]);
    chk(req, "swap",   xl_swap,   hi[29:26]);
  endtask

  task automatic put(input logic [7:0] i, input logic [31:0] lo, input logic [31:0] hi);
    bus_wr(A_LO, lo);
    bus_wr(A_HI, hi);
    bus_wr(A_IX, {22'd0, 2'b10, i});
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    bus_rd(A_LO, r); chk("R1", "lo", r, 0);
    bus_rd(A_HI, r); chk("R1", "hi", r, 0);
    bus_rd(A_IX, r); chk("R1", "idx", r, 0);
    xl_read(8'h80);
    chk_xl("R1", 32'h0, 32'h0);

    // R4/R5 table walk: commit then read back through both paths
    for (int v = 0; v < NV; v++) put(VECS[v].idx, VECS[v].lo, VECS[v].hi);
    for (int v = 0; v < NV; v++) begin
      xl_read(VECS[v].idx);
      chk_xl("R5", VECS[v].lo, VECS[v].hi);
      bus_wr(A_LO, 32'h0); bus_wr(A_HI, 32'h0);
      bus_wr(A_IX, {22'd0, 2'b01, VECS[v].idx});
      bus_rd(A_LO, r); chk("R6", "load lo", r, VECS[v].lo);
      bus_rd(A_HI, r); chk("R6", "load hi", r, VECS[v].hi & 32'h3FFF_FFFF);
      bus_rd(A_IX, r); chk("R4", "idx readback", r, {24'd0, VECS[v].idx});
    end

    // R3 reserved bits
    bus_wr(A_HI, 32'hFFFF_FFFF);
    bus_rd(A_HI, r); chk("R3", "hi rsvd", r, 32'h3FFF_FFFF);
    bus_wr(A_IX, 32'hFFFF_FC05);
    bus_rd(A_IX, r); chk("R3", "idx rsvd", r, 32'h0000_0005);

    // R2 unmapped offset
    bus_wr(A_LO, 32'h0BAD_F00D);
    bus_wr(8'h54, 32'hFFFF_FFFF);
    bus_rd(8'h54, r); chk("R2", "unmapped read", r, 0);
    bus_rd(A_LO, r); chk("R2", "lo after stray", r, 32'h0BAD_F00D);
    bus_wr(8'h4E, 32'hFFFF_FFFF);
    bus_rd(A_HI, r); chk("R2", "hi after stray", r, 32'h3FFF_FFFF);

    // R7 both strobes: commit performed, load skipped
    put(8'h0A, 32'h1111_1111, 32'h0222_2222);
    bus_wr(A_LO, 32'h7777_7777); bus_wr(A_HI, 32'h0333_3333);
    bus_wr(A_IX, {22'd0, 2'b11, 8'h0A});
    bus_rd(A_LO, r); chk("R7", "lo kept", r, 32'h7777_7777);
    bus_rd(A_HI, r); chk("R7", "hi kept", r, 32'h0333_3333);
    xl_read(8'h0A);
    chk_xl("R7", 32'h7777_7777, 32'h0333_3333);

    // R8 load right after commit sees new entry
    put(8'h14, 32'hC0DE_0001, 32'h1BAD_0002);
    bus_wr(A_IX, {22'd0, 2'b01, 8'h14});
    bus_rd(A_LO, r); chk("R8", "lo after commit", r, 32'hC0DE_0001);
    put(8'h15, 32'h4444_0000, 32'h0055_0000);
    xl_read(8'h15);
    chk_xl("R8", 32'h4444_0000, 32'h0055_0000);

    // R9 translator read colliding with commit returns old entry
    put(8'h1E, 32'h0000_1234, 32'h0000_0005);
    bus_wr(A_LO, 32'hFEDC_BA98); bus_wr(A_HI, 32'h1357_9BDF);
    bus_addr = A_IX; bus_wdata = {22'd0, 2'b10, 8'h1E}; bus_we = 1'b1;
    xl_idx = 8'h1E; xl_rd = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; xl_rd = 1'b0;
    chk_xl("R9", 32'h0000_1234, 32'h0000_0005);
    xl_read(8'h1E);
    chk_xl("R9", 32'hFEDC_BA98, 32'h1357_9BDF);

    // R10 outputs hold without a request
    xl_idx = 8'hFF;
    bus_wr(A_IX, {22'd0, 2'b10, 8'h1E});
    @(negedge clk);
    chk_xl("R10", 32'hFEDC_BA98, 32'h1357_9BDF);

    // R1 reset again clears the table
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    xl_read(8'hFF);
    chk_xl("R1", 32'h0, 32'h0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule